// File: doc/BRIEF.md
# SMBus Host Command Sequencer

This block sits between a host controller and a byte-level I2C engine. It takes one command request (target address, command code, protocol selector, write data and, for block writes, a byte count) and turns it into the ordered list of bus primitives that the selected SMBus protocol needs. Each primitive is handed to the engine over a valid/ready handshake. The primitives are start-for-write, start-for-read, transmit byte, receive byte, NACK and stop.

Nine protocols are covered: quick command, send byte, receive byte, write byte, read byte, write word, read word, block write and block read. Word data travels low byte first. Every read protocol that carries a command code inserts a repeated start between the command byte and the read phase. Block payloads pass through a 32-byte buffer. The host fills or drains this buffer through its own byte port while the sequencer is idle. When a request finishes, the received byte or word and the block length are left on the outputs.

Top module: `smbus_host_seq`

## Requirements
- R1: A quick command (protocol code 0) emits only a start followed by a stop. The start is start-for-read (op 1) when `req_rd` is 1 and start-for-write (op 0) otherwise. Every start carries the byte {address[6:0], direction bit}, where the direction bit is 1 for read. Primitive op codes are: 0 start-write, 1 start-read, 2 transmit, 3 receive, 4 NACK, 5 stop. Non-transmit primitives carry byte 0.
- R2: Send byte (code 1) emits start-write, transmit of `req_wdata[7:0]`, then stop. Receive byte (code 2) emits start-read, one receive, NACK, then stop, and returns the byte in `rd_data[7:0]` with `rd_data[15:8]` = 0.
- R3: Write byte (code 3) emits start-write, command, `req_wdata[7:0]`, then stop. Write word (code 5) emits start-write, command, `req_wdata[7:0]`, `req_wdata[15:8]`, then stop.
- R4: Read byte (code 4) and read word (code 6) emit start-write, command, a repeated start-read, one or two receives, NACK, then stop. The first received byte lands in `rd_data[7:0]` and the second in `rd_data[15:8]`.
- R5: Block write (code 7) clamps `req_blen` to at most 32. It then emits start-write, command, the clamped length as a transmitted byte, buffer entries 0 up to length-1 in order, then stop. `blk_len` reports the clamped length.
- R6: Block read (code 8) emits start-write, command, start-read, then a receive whose byte is the length. A length above 32 is treated as 0. It then emits that many receives, stored in buffer entries from 0 upward, followed by NACK and stop. `blk_len` reports the accepted length.
- R7: `busy` and `prim_valid` are 0 after reset. They go high in the cycle after a request is accepted and stay high until the stop primitive is handshaken. `done` is high for exactly the one cycle that follows, and `busy` is 0 in that cycle.
- R8: A request presented while busy is dropped, and so is a request with a protocol code above 8. Neither one causes any primitive to be issued.
- R9: While `prim_valid` is high and `prim_ready` is low, `prim_op` and `prim_byte` hold their values.
- R10: A buffer write through the host port (`buf_we`) takes effect only while the block is idle. While busy it is ignored, even in a cycle in which the sequencer itself stores a received block byte. `buf_rdata` always shows the entry at `buf_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_proto | input | 4 | Protocol code 0..8 |
| req_addr | input | 7 | Target address |
| req_cmd | input | 8 | Command code |
| req_wdata | input | 16 | Byte/word write data, low byte first |
| req_blen | input | 8 | Block write length before clamping |
| req_rd | input | 1 | Quick command direction, 1 = read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Received byte or word |
| blk_len | output | 6 | Clamped or accepted block length |
| prim_valid | output | 1 | Primitive offered to the engine |
| prim_ready | input | 1 | Engine takes the primitive |
| prim_op | output | 3 | Primitive op code |
| prim_byte | output | 8 | Address/direction or data byte |
| prim_rdata | input | 8 | Byte returned with a receive handshake |
| buf_we | input | 1 | Host buffer write enable |
| buf_addr | input | 5 | Host buffer index |
| buf_wdata | input | 8 | Host buffer write data |
| buf_rdata | output | 8 | Host buffer read data |

## Verification
Two buffer writers can meet in the same cycle: the sequencer storing a received block byte, and the host port writing. The bench holds `buf_we` high at entry 1 for the whole of a block read, so the host write lands on the very edge where entry 1 is received. The test passes if entry 1 holds the received byte afterwards. A second collision is a new request arriving on the same edge as the stop handshake. The bench keeps `req_valid` asserted through a whole block write and expects exactly one primitive list and one done pulse.

// File: rtl/smbseq_pkg.sv
package smbseq_pkg;

    localparam int ADDR_W  = 7;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int BLK_MAX = 32;
    localparam int BUF_AW  = $clog2(BLK_MAX);
    localparam int LEN_W   = $clog2(BLK_MAX + 1);

    typedef enum logic [3:0] {
        P_QUICK = 4'd0, P_SEND = 4'd1, P_RECV = 4'd2,
        P_WRB   = 4'd3, P_RDB  = 4'd4, P_WRW  = 4'd5,
        P_RDW   = 4'd6, P_BWR  = 4'd7, P_BRD  = 4'd8
    } proto_e;

    typedef enum logic [2:0] {
        OP_STW = 3'd0, OP_STR = 3'd1, OP_TX = 3'd2,
        OP_RX  = 3'd3, OP_NACK = 3'd4, OP_STOP = 3'd5
    } prim_e;

    typedef enum logic [3:0] {
        PH_IDLE, PH_START, PH_CMD, PH_LEN, PH_WDAT,
        PH_RSTART, PH_RLEN, PH_RDAT, PH_NACK, PH_STOP
    } phase_e;

    typedef struct packed {
        proto_e              proto;
        logic [ADDR_W-1:0]   addr;
        logic [BYTE_W-1:0]   cmd;
        logic [WORD_W-1:0]   wdata;
        logic                rd;
    } req_t;

    function automatic logic proto_known(input logic [3:0] p);
        return p <= 4'(P_BRD);
    endfunction

    // Outgoing block length: oversize is cut to the maximum.
    function automatic logic [LEN_W-1:0] clamp_tx(input logic [BYTE_W-1:0] n);
        return (n > BYTE_W'(BLK_MAX)) ? LEN_W'(BLK_MAX) : n[LEN_W-1:0];
    endfunction

    // Incoming block length: oversize is refused as empty.
    function automatic logic [LEN_W-1:0] accept_rx(input logic [BYTE_W-1:0] n);
        return (n > BYTE_W'(BLK_MAX)) ? '0 : n[LEN_W-1:0];
    endfunction

endpackage

// File: rtl/smbseq_step.sv
module smbseq_step
    import smbseq_pkg::*;
(
    input  phase_e             ph,
    input  req_t               rq,
    input  logic [LEN_W-1:0]   cnt,
    input  logic [LEN_W-1:0]   nbytes,
    input  logic [BYTE_W-1:0]  buf_byte,
    input  logic [BYTE_W-1:0]  rx_byte,
    output prim_e              op,
    output logic [BYTE_W-1:0]  tx_byte,
    output phase_e             nxt_ph
);
    logic last;
    logic start_rd;

    assign last     = (cnt == nbytes - LEN_W'(1));
    assign start_rd = (rq.proto == P_RECV) || (rq.proto == P_QUICK && rq.rd);

    always_comb begin
        op      = OP_STOP;
        tx_byte = '0;
        nxt_ph  = PH_IDLE;
        unique case (ph)
            PH_START: begin
                op      = start_rd ? OP_STR : OP_STW;
                tx_byte = {rq.addr, start_rd};
                unique case (rq.proto)
                    P_QUICK: nxt_ph = PH_STOP;
                    P_SEND:  nxt_ph = PH_WDAT;
                    P_RECV:  nxt_ph = PH_RDAT;
                    default: nxt_ph = PH_CMD;
                endcase
            end
            PH_CMD: begin
                op      = OP_TX;
                tx_byte = rq.cmd;
                unique case (rq.proto)
                    P_WRB, P_WRW: nxt_ph = PH_WDAT;
                    P_BWR:        nxt_ph = PH_LEN;
                    default:      nxt_ph = PH_RSTART;
                endcase
            end
            PH_LEN: begin
                op      = OP_TX;
                tx_byte = BYTE_W'(nbytes);
                nxt_ph  = (nbytes == '0) ? PH_STOP : PH_WDAT;
            end
            PH_WDAT: begin
                op      = OP_TX;
                if (rq.proto == P_BWR) tx_byte = buf_byte;
                else if (cnt[0])       tx_byte = rq.wdata[WORD_W-1:BYTE_W];
                else                   tx_byte = rq.wdata[BYTE_W-1:0];
                nxt_ph  = last ? PH_STOP : PH_WDAT;
            end
            PH_RSTART: begin
                op      = OP_STR;
                tx_byte = {rq.addr, 1'b1};
                nxt_ph  = (rq.proto == P_BRD) ? PH_RLEN : PH_RDAT;
            end
            PH_RLEN: begin
                op     = OP_RX;
                nxt_ph = (accept_rx(rx_byte) == '0) ? PH_NACK : PH_RDAT;
            end
            PH_RDAT: begin
                op     = OP_RX;
                nxt_ph = last ? PH_NACK : PH_RDAT;
            end
            PH_NACK: begin
                op     = OP_NACK;
                nxt_ph = PH_STOP;
            end
            PH_STOP: begin
                op     = OP_STOP;
                nxt_ph = PH_IDLE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/smbseq_buf.sv
module smbseq_buf
    import smbseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [BUF_AW-1:0]  waddr,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic [BUF_AW-1:0]  raddr_a,
    output logic [BYTE_W-1:0]  rdata_a,
    input  logic [BUF_AW-1:0]  raddr_b,
    output logic [BYTE_W-1:0]  rdata_b
);
    logic [BYTE_W-1:0] mem [BLK_MAX];

    for (genvar i = 0; i < BLK_MAX; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)                                 mem[i] <= '0;
            else if (we && waddr == BUF_AW'(i))      mem[i] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/smbus_host_seq.sv
module smbus_host_seq
    import smbseq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [3:0]               req_proto,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [BYTE_W-1:0]        req_cmd,
    input  logic [WORD_W-1:0]        req_wdata,
    input  logic [BYTE_W-1:0]        req_blen,
    input  logic                     req_rd,
    output logic                     busy,
    output logic                     done,
    output logic [WORD_W-1:0]        rd_data,
    output logic [LEN_W-1:0]         blk_len,
    output logic                     prim_valid,
    input  logic                     prim_ready,
    output logic [2:0]               prim_op,
    output logic [BYTE_W-1:0]        prim_byte,
    input  logic [BYTE_W-1:0]        prim_rdata,
    input  logic                     buf_we,
    input  logic [BUF_AW-1:0]        buf_addr,
    input  logic [BYTE_W-1:0]        buf_wdata,
    output logic [BYTE_W-1:0]        buf_rdata
);
    phase_e            ph, nxt_ph;
    req_t              rq;
    logic [LEN_W-1:0]  cnt, nbytes;
    prim_e             op;
    logic [BYTE_W-1:0] tx_byte, seq_buf_byte;
    logic              accept, fire, seq_we, mem_we;
    logic [BUF_AW-1:0] mem_addr;
    logic [BYTE_W-1:0] mem_wdata;

    assign busy       = (ph != PH_IDLE);
    assign prim_valid = busy;
    assign prim_op    = op;
    assign prim_byte  = tx_byte;
    assign fire       = prim_valid && prim_ready;
    assign accept     = !busy && req_valid && proto_known(req_proto);

    smbseq_step u_step (
        .ph(ph), .rq(rq), .cnt(cnt), .nbytes(nbytes),
        .buf_byte(seq_buf_byte), .rx_byte(prim_rdata),
        .op(op), .tx_byte(tx_byte), .nxt_ph(nxt_ph)
    );

    // Sequencer store has the buffer to itself while busy.
    always_comb begin
        seq_we    = fire && ph == PH_RDAT && rq.proto == P_BRD;
        mem_we    = seq_we || (buf_we && !busy);
        mem_addr  = seq_we ? cnt[BUF_AW-1:0] : buf_addr;
        mem_wdata = seq_we ? prim_rdata : buf_wdata;
    end

    smbseq_buf u_buf (
        .clk(clk), .rst(rst),
        .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .raddr_a(cnt[BUF_AW-1:0]), .rdata_a(seq_buf_byte),
        .raddr_b(buf_addr), .rdata_b(buf_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            rq      <= '0;
            cnt     <= '0;
            nbytes  <= '0;
            rd_data <= '0;
            blk_len <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                rq      <= '{proto: proto_e'(req_proto), addr: req_addr, cmd: req_cmd,
                             wdata: req_wdata, rd: req_rd};
                ph      <= PH_START;
                cnt     <= '0;
                rd_data <= '0;
                blk_len <= '0;
                unique case (proto_e'(req_proto))
                    P_WRW, P_RDW: nbytes <= LEN_W'(2);
                    P_BWR: begin
                        nbytes  <= clamp_tx(req_blen);
                        blk_len <= clamp_tx(req_blen);
                    end
                    P_BRD, P_QUICK: nbytes <= '0;
                    default:        nbytes <= LEN_W'(1);
                endcase
            end else if (fire) begin
                ph   <= nxt_ph;
                done <= (ph == PH_STOP);
                if (ph == PH_WDAT || ph == PH_RDAT) cnt <= cnt + LEN_W'(1);
                if (ph == PH_RDAT && rq.proto != P_BRD) begin
                    if (cnt[0]) rd_data[WORD_W-1:BYTE_W] <= prim_rdata;
                    else        rd_data[BYTE_W-1:0]      <= prim_rdata;
                end
                if (ph == PH_RLEN) begin
                    nbytes  <= accept_rx(prim_rdata);
                    blk_len <= accept_rx(prim_rdata);
                end
            end
        end
    end

    // R9: an offered primitive is held until taken
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (prim_valid && !prim_ready) |=> (prim_valid && $stable(prim_op) && $stable(prim_byte)));

    // R7: done follows a busy cycle and is never seen with busy
    assert_done_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R5 / R6: reported block length never exceeds the buffer
    assert_blen_R5: assert property (@(posedge clk) disable iff (rst)
        blk_len <= LEN_W'(BLK_MAX));

    // R6: data-phase index stays inside the agreed byte count
    assert_cnt_R6: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_WDAT || ph == PH_RDAT) |-> (cnt < nbytes));

    // R8: with no request the idle block stays idle
    assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |=> !busy);
endmodule

// File: tb/sim_smbus_host_seq.sv
module sim_smbus_host_seq;
    localparam int CLK_PERIOD = 10;
    localparam int OP_STW = 0, OP_STR = 1, OP_TX = 2, OP_RX = 3, OP_NACK = 4, OP_STOP = 5;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_rd = 1'b0;
    logic [3:0] req_proto = '0;
    logic [6:0] req_addr = '0;
    logic [7:0] req_cmd = '0, req_blen = '0;
    logic [15:0] req_wdata = '0;
    logic busy, done, prim_valid, prim_ready = 1'b0;
    logic [15:0] rd_data;
    logic [5:0] blk_len;
    logic [2:0] prim_op;
    logic [7:0] prim_byte, prim_rdata = '0;
    logic buf_we = 1'b0;
    logic [4:0] buf_addr = '0;
    logic [7:0] buf_wdata = '0, buf_rdata;

    int checks = 0, fails = 0;
    int n = 0, ne = 0, rxi = 0;
    logic [10:0] logv [80];
    logic [10:0] expv [80];
    logic [7:0] rxq [40];
    bit stall = 0, tog = 0, hammer = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_host_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_proto(req_proto),
        .req_addr(req_addr), .req_cmd(req_cmd), .req_wdata(req_wdata),
        .req_blen(req_blen), .req_rd(req_rd), .busy(busy), .done(done),
        .rd_data(rd_data), .blk_len(blk_len), .prim_valid(prim_valid),
        .prim_ready(prim_ready), .prim_op(prim_op), .prim_byte(prim_byte),
        .prim_rdata(prim_rdata), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    // Engine model: answers at the falling edge, logs what it takes.
    always @(negedge clk) begin
        if (prim_valid && (!stall || tog)) begin
            prim_ready = 1'b1;
            if (n < 80) logv[n] = {prim_op, prim_byte};
            n++;
            if (prim_op == 3'(OP_RX)) begin
                prim_rdata = rxq[rxi];
                rxi++;
            end
        end else begin
            prim_ready = 1'b0;
        end
        tog = ~tog;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input int op, input int b);
        expv[ne] = {3'(op), 8'(b)};
        ne++;
    endtask

    task automatic cmp_log(input string tag);
        chk(n == ne, {tag, " primitive count"}, n, ne);
        for (int i = 0; i < ne && i < n; i++)
            chk(logv[i] == expv[i], {tag, " primitive"}, logv[i], expv[i]);
    endtask

    task automatic run_req(input int p, input int a, input int c, input int w,
                           input int bl, input bit rd, input bit poke);
        int cyc;
        @(negedge clk);
        n = 0; ne = 0; rxi = 0;
        req_proto = 4'(p); req_addr = 7'(a); req_cmd = 8'(c);
        req_wdata = 16'(w); req_blen = 8'(bl); req_rd = rd; req_valid = 1'b1;
        @(negedge clk);
        if (!hammer) req_valid = 1'b0;
        else req_proto = 4'd0;
        chk(busy && prim_valid, "R7 busy after accept", busy, 1);
        buf_we = poke;
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        buf_we = 1'b0; req_valid = 1'b0;
        chk(done, "R7 done pulse", done, 1);
        chk(!busy, "R7 busy low with done", busy, 0);
        @(negedge clk);
        chk(!done, "R7 done one cycle", done, 0);
    endtask

    task automatic buf_write(input int a, input int d);
        @(negedge clk);
        buf_we = 1'b1; buf_addr = 5'(a); buf_wdata = 8'(d);
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic buf_read(input int a, output logic [7:0] d);
        @(negedge clk);
        buf_addr = 5'(a);
        #1 d = buf_rdata;
    endtask

    task automatic t_reset();
        chk(!busy && !prim_valid && !done, "R7 reset idle", {busy, prim_valid, done}, 0);
        chk(rd_data == 0 && blk_len == 0, "R7 reset outputs", rd_data, 0);
    endtask

    task automatic t_quick();
        run_req(0, 7'h50, 0, 0, 0, 0, 0);
        push(OP_STW, 8'hA0); push(OP_STOP, 0);
        cmp_log("R1 quick write");
        run_req(0, 7'h50, 0, 0, 0, 1, 0);
        push(OP_STR, 8'hA1); push(OP_STOP, 0);
        cmp_log("R1 quick read");
    endtask

    task automatic t_send_recv();
        run_req(1, 7'h2B, 0, 16'h773C, 0, 0, 0);
        push(OP_STW, 8'h56); push(OP_TX, 8'h3C); push(OP_STOP, 0);
        cmp_log("R2 send byte");
        rxq[0] = 8'h9E;
        run_req(2, 7'h2B, 0, 0, 0, 0, 0);
        push(OP_STR, 8'h57); push(OP_RX, 0); push(OP_NACK, 0); push(OP_STOP, 0);
        cmp_log("R2 receive byte");
        chk(rd_data == 16'h009E, "R2 receive data", rd_data, 16'h009E);
    endtask

    task automatic t_writes();
        run_req(3, 7'h10, 8'h11, 16'h5522, 0, 0, 0);
        push(OP_STW, 8'h20); push(OP_TX, 8'h11); push(OP_TX, 8'h22); push(OP_STOP, 0);
        cmp_log("R3 write byte");
        run_req(5, 7'h10, 8'h12, 16'hBEEF, 0, 0, 0);
        push(OP_STW, 8'h20); push(OP_TX, 8'h12); push(OP_TX, 8'hEF); push(OP_TX, 8'hBE);
        push(OP_STOP, 0);
        cmp_log("R3 write word low first");
    endtask

    task automatic t_reads();
        rxq[0] = 8'h5A;
        run_req(4, 7'h33, 8'h21, 0, 0, 0, 0);
        push(OP_STW, 8'h66); push(OP_TX, 8'h21); push(OP_STR, 8'h67); push(OP_RX, 0);
        push(OP_NACK, 0); push(OP_STOP, 0);
        cmp_log("R4 read byte");
        chk(rd_data == 16'h005A, "R4 read byte data", rd_data, 16'h005A);
        stall = 1;   // R9: engine takes a primitive only every other cycle
        rxq[0] = 8'h34; rxq[1] = 8'h12;
        run_req(6, 7'h33, 8'h22, 0, 0, 0, 0);
        stall = 0;
        push(OP_STW, 8'h66); push(OP_TX, 8'h22); push(OP_STR, 8'h67); push(OP_RX, 0);
        push(OP_RX, 0); push(OP_NACK, 0); push(OP_STOP, 0);
        cmp_log("R4 R9 read word with stalls");
        chk(rd_data == 16'h1234, "R4 word low byte first", rd_data, 16'h1234);
    endtask

    task automatic t_block_write();
        for (int i = 0; i < 32; i++) buf_write(i, i * 3 + 1);
        run_req(7, 7'h40, 8'h31, 0, 5, 0, 0);
        push(OP_STW, 8'h80); push(OP_TX, 8'h31); push(OP_TX, 5);
        for (int i = 0; i < 5; i++) push(OP_TX, i * 3 + 1);
        push(OP_STOP, 0);
        cmp_log("R5 block write 5");
        chk(blk_len == 5, "R5 block write length", blk_len, 5);
        hammer = 1;  // R8: requests keep arriving while busy
        run_req(7, 7'h40, 8'h32, 0, 40, 0, 0);
        hammer = 0;
        push(OP_STW, 8'h80); push(OP_TX, 8'h32); push(OP_TX, 32);
        for (int i = 0; i < 32; i++) push(OP_TX, i * 3 + 1);
        push(OP_STOP, 0);
        cmp_log("R5 R8 block write clamped, extra requests dropped");
        chk(blk_len == 32, "R5 clamped length", blk_len, 32);
        chk(!busy, "R8 no second sequence", busy, 0);
        run_req(7, 7'h40, 8'h33, 0, 0, 0, 0);
        push(OP_STW, 8'h80); push(OP_TX, 8'h33); push(OP_TX, 0); push(OP_STOP, 0);
        cmp_log("R5 block write empty");
    endtask

    task automatic t_block_read();
        logic [7:0] d;
        rxq[0] = 3; rxq[1] = 8'hA0; rxq[2] = 8'hA1; rxq[3] = 8'hA2;
        buf_addr = 5'd1; buf_wdata = 8'hEE;   // R10 collision: host write to entry 1 throughout
        run_req(8, 7'h48, 8'h41, 0, 0, 0, 1);
        push(OP_STW, 8'h90); push(OP_TX, 8'h41); push(OP_STR, 8'h91);
        for (int i = 0; i < 4; i++) push(OP_RX, 0);
        push(OP_NACK, 0); push(OP_STOP, 0);
        cmp_log("R6 block read 3");
        chk(blk_len == 3, "R6 accepted length", blk_len, 3);
        for (int i = 0; i < 3; i++) begin
            buf_read(i, d);
            chk(d == 8'(8'hA0 + i), "R6 R10 block read store", d, 8'hA0 + i);
        end
        rxq[0] = 33;
        run_req(8, 7'h48, 8'h42, 0, 0, 0, 0);
        push(OP_STW, 8'h90); push(OP_TX, 8'h42); push(OP_STR, 8'h91); push(OP_RX, 0);
        push(OP_NACK, 0); push(OP_STOP, 0);
        cmp_log("R6 block read length 33 refused");
        chk(blk_len == 0, "R6 refused length", blk_len, 0);
        rxq[0] = 32;
        for (int i = 1; i <= 32; i++) rxq[i] = 8'(8'hC0 + i);
        run_req(8, 7'h48, 8'h43, 0, 0, 0, 0);
        chk(n == 38, "R6 block read 32 count", n, 38);
        chk(blk_len == 32, "R6 full length", blk_len, 32);
        buf_read(31, d);
        chk(d == 8'hE0, "R6 last entry", d, 8'hE0);
    endtask

    task automatic t_ignored();
        logic [7:0] d;
        buf_write(20, 8'h55);
        rxq[0] = 2; rxq[1] = 8'h01; rxq[2] = 8'h02;
        buf_addr = 5'd20; buf_wdata = 8'hEE;
        run_req(8, 7'h48, 8'h44, 0, 0, 0, 1);
        buf_read(20, d);
        chk(d == 8'h55, "R10 host write ignored while busy", d, 8'h55);
        buf_write(20, 8'h66);
        buf_read(20, d);
        chk(d == 8'h66, "R10 host write when idle", d, 8'h66);
        @(negedge clk);
        n = 0;
        req_proto = 4'd9; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!busy && !prim_valid, "R8 unknown protocol ignored", busy, 0);
        repeat (3) @(negedge clk);
        chk(n == 0, "R8 no primitive for unknown protocol", n, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_quick();
        t_send_recv();
        t_writes();
        t_reads();
        t_block_write();
        t_block_read();
        t_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule